// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the word address for a fixed four-beat burst. A load cycle captures a full starting word address. Each following step cycle moves to the next beat. Only the two low address bits take part in the sequence. The upper bits repeat the captured start for as long as the burst lasts.

A static order select input chooses between two beat orders. The interleaved order, which is the default, places the start XOR the beat number on the low bits. The linear order counts the low bits upward from the start and wraps modulo four. The order select is meant to be tied off and must not change while the block operates.

A hold input freezes all state. A last-beat flag marks the fourth beat. Stepping past the fourth beat returns to the first beat of the same burst.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `word_addr` is all zeros, the beat number is 0 and `last_beat` is 0.
- R2: At a rising edge with `hold`=0 and `step`=0, the block captures `addr_in` as the start and sets the beat number to 0. From the next cycle, `word_addr` equals the captured `addr_in` and `last_beat` is 0, in both orders.
- R3: At a rising edge with `hold`=0 and `step`=1, the beat number rises by one and wraps from 3 back to 0. After four steps, `word_addr` equals the start again.
- R4: With `order_sel`=1 (interleaved), `word_addr[1:0]` is the start's low two bits XOR the beat number. Starts 00, 01, 10 and 11 therefore give 00,01,10,11 / 01,00,11,10 / 10,11,00,01 / 11,10,01,00.
- R5: With `order_sel`=0 (linear), `word_addr[1:0]` is (start low bits + beat number) mod 4.
- R6: `word_addr[ADDR_W-1:2]` keeps the captured start's upper bits through every step, including the wrap, and is never incremented.
- R7: At a rising edge with `hold`=1, the start and the beat number stay unchanged whatever `step` and `addr_in` carry, so `word_addr` and `last_beat` do not change.
- R8: `last_beat` is 1 exactly when the beat number is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 freezes all state for this edge |
| step | input | 1 | 1 advances the beat, 0 loads `addr_in` |
| order_sel | input | 1 | 1 selects interleaved order, 0 selects linear; static |
| addr_in | input | ADDR_W | Starting word address, captured on a load |
| word_addr | output | ADDR_W | Current beat's word address |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
Every result is registered once. A load, step or hold presented before a rising edge shows on `word_addr` and `last_beat` right after that edge, and no earlier. The bench changes inputs on the falling edge. It updates its model of the start and the beat number at the rising edge, from the inputs it drove. It then compares the outputs one nanosecond after that edge, so each comparison checks the effect of exactly one edge. Reset is asserted between the interleaved and linear phases, so the order select never changes during operation.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  // Interleaved order: low bits are start XOR beat number
  function automatic beat_t low_interleave(input beat_t start_lo, input beat_t beat);
    return start_lo ^ beat;
  endfunction

  // Linear order: low bits count up from the start, modulo the burst length
  function automatic beat_t low_linear(input beat_t start_lo, input beat_t beat);
    return beat_t'(start_lo + beat);
  endfunction

  function automatic beat_t beat_succ(input beat_t beat);
    return beat_t'(beat + 1'b1);
  endfunction

  function automatic logic beat_is_last(input beat_t beat);
    return beat == beat_t'(BEATS - 1);
  endfunction
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] start_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_addr <= '0;
    else if (load_evt) start_addr <= addr_in;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_evt,
  input  logic  step_evt,
  output beat_t beat,
  output logic  last,
  output logic  wrap_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat <= '0;
    else if (load_evt) beat <= '0;
    else if (step_evt) beat <= beat_succ(beat);
  end

  assign last     = beat_is_last(beat);
  assign wrap_evt = step_evt && last;

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (beat == '0));

  assert_last_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && beat == beat_t'(BEATS - 2)) |=> last);

  assert_last_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !last);
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_seq_pkg::*;
(
  input  logic  order_sel,
  input  beat_t start_lo,
  input  beat_t beat,
  output beat_t seq_lo
);
  beat_t il_lo;
  beat_t ln_lo;

  assign il_lo  = low_interleave(start_lo, beat);
  assign ln_lo  = low_linear(start_lo, beat);
  assign seq_lo = order_sel ? il_lo : ln_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              step,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              last_beat
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              load_evt;
  logic              step_evt;
  logic              wrap_evt;
  logic [ADDR_W-1:0] start_addr;
  beat_t             beat;
  beat_t             seq_lo;

  assign load_evt = !hold && !step;
  assign step_evt = !hold && step;

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_evt   (load_evt),
    .addr_in    (addr_in),
    .start_addr (start_addr)
  );

  burst_beat_ctr u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat     (beat),
    .last     (last_beat),
    .wrap_evt (wrap_evt)
  );

  burst_low_map u_map (
    .order_sel (order_sel),
    .start_lo  (start_addr[BEAT_W-1:0]),
    .beat      (beat),
    .seq_lo    (seq_lo)
  );

  assign word_addr[BEAT_W-1:0] = seq_lo;

  for (genvar i = 0; i < UP_W; i++) begin : g_upper
    assign word_addr[BEAT_W+i] = start_addr[BEAT_W+i];
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (word_addr == $past(addr_in)) && !last_beat);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(word_addr) && $stable(last_beat));

  assert_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

  assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !order_sel) |=>
      (word_addr[BEAT_W-1:0] == beat_t'($past(word_addr[BEAT_W-1:0]) + 1'b1)));

  assert_wrap_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (word_addr == start_addr));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold = 1'b0;
  logic          step = 1'b0;
  logic          order_sel = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] word_addr;
  logic          last_beat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_start = '0;
  int            m_beat = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .hold(hold), .step(step),
    .order_sel(order_sel), .addr_in(addr_in),
    .word_addr(word_addr), .last_beat(last_beat)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int b, input logic il);
    int lo;
    if (il) lo = {30'd0, s[1] ^ b[1], s[0] ^ b[0]};
    else    lo = (int'(s[1:0]) + b) % 4;
    return {s[AW-1:2], lo[1:0]};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive on falling edge, model at rising edge, compare 1 ns later
  task automatic cycle(input logic h, input logic st, input logic [AW-1:0] a);
    string tag;
    logic [AW-1:0] prev_up;
    @(negedge clk);
    hold = h; step = st; addr_in = a;
    prev_up = word_addr[AW-1:2];
    @(posedge clk);
    if (h) tag = "R7";
    else if (!st) begin tag = "R2"; m_start = a; m_beat = 0; end
    else begin tag = order_sel ? "R4" : "R5"; m_beat = (m_beat + 1) % 4; end
    #1;
    check(tag, word_addr, exp_addr(m_start, m_beat, order_sel));
    check("R8", {15'd0, last_beat}, {15'd0, m_beat == 3});
    if (!h && st) check("R6", {2'd0, word_addr[AW-1:2]}, {2'd0, prev_up});
  endtask

  task automatic do_reset(input logic il);
    @(negedge clk);
    rst_n = 1'b0; order_sel = il; hold = 1'b0; step = 1'b1;
    m_start = '0; m_beat = 0;
    #7;
    check("R1", word_addr, '0);
    check("R1", {15'd0, last_beat}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic directed(input logic il);
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] a;
      a = {14'h2A5C + 14'(s), 2'(s)};
      cycle(1'b0, 1'b0, a);
      for (int k = 0; k < 4; k++) cycle(1'b0, 1'b1, 16'hFFFF);
      // R3: four steps return to the start address
      check("R3", word_addr, a);
      cycle(1'b1, 1'b0, 16'h1234);
      cycle(1'b1, 1'b1, 16'h0);
    end
    // upper bits all ones must not carry on wrap (R6)
    cycle(1'b0, 1'b0, 16'hFFFF);
    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b1, 16'h0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic h, st;
      h  = ($urandom % 5) == 0;
      st = ($urandom % 4) != 0;
      cycle(h, st, 16'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0417));
    do_reset(1'b1);
    directed(1'b1);
    random_run(600);
    do_reset(1'b0);
    directed(1'b0);
    random_run(600);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule